// File: doc/BRIEF.md
# Data-Strobe Pair-to-Serial Transmit Stage

This block turns two-bit-wide data and strobe words, presented once per cycle of a slow write clock, into single-bit serial data and strobe lines clocked by a transmit clock running at twice the write rate. Each write cycle it takes one even/odd pair of data bits and one pair of strobe bits. The strobe bits are already computed upstream, so the block only places bits in time and does no line encoding. The two clocks share one source, but their relative phase is not fixed.

A captured pair sits in a write-domain holding register. A toggle that flips once per write cycle tells the transmit domain when a new pair is ready, and the transmit domain then loads the pair into a short shift stage. The even bit goes out first and the odd bit second.

After the shift stage, a selector applies two controls. Remote loopback sends the received serial data and strobe straight back out. The output-enable flag stands in for a tri-state driver: when it is low, both lines are parked at 0. Reset is synchronous and active low in both clock domains.

Top module: `ds_tx_serializer`

## Requirements
- R1: For every captured pair, `tx_data` carries `wr_data[0]` for one transmit period and then `wr_data[1]` for the next period.
- R2: `tx_strobe` carries `wr_strobe[0]` and then `wr_strobe[1]` in the same two transmit periods as the matching data bits.
- R3: With output enabled, loopback off and reset high, every write cycle is serialized without gaps. The even bit of a pair captured at a write edge is visible after the second transmit edge that follows that write edge, and the odd bit is visible after the third.
- R4: While `tx_oe` is 0, `tx_data` and `tx_strobe` are both 0, whatever the values of `rst_n`, `rmt_loop` and the write inputs.
- R5: While `tx_oe` is 1 and `rmt_loop` is 1, `tx_data` equals `rx_data` and `tx_strobe` equals `rx_strobe` in the same cycle, without a register in the path.
- R6: While `rst_n` is 0 (active low, held for at least 3 write cycles), the serial stage and the holding register are cleared, so with `tx_oe`=1 and `rmt_loop`=0 both outputs read 0 even when the write inputs are all ones.
- R7: Clearing `rmt_loop` brings back the serialized stream at once. Pairs written after the switch come out with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, half the transmit rate |
| tclk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_oe | input | 1 | Output enable; 0 parks both serial lines at 0 |
| rmt_loop | input | 1 | Remote loopback select |
| wr_data | input | 2 | Data pair; bit 0 even (sent first), bit 1 odd |
| wr_strobe | input | 2 | Strobe pair; bit 0 even, bit 1 odd |
| rx_data | input | 1 | Received serial data, used for loopback |
| rx_strobe | input | 1 | Received serial strobe, used for loopback |
| tx_data | output | 1 | Serial data out |
| tx_strobe | output | 1 | Serial strobe out |

## Verification
A stuck or misordered pending bit shows up one transmit period after a load, as an odd bit that repeats the even bit or a stale value. A missed or doubled reload makes a whole pair repeat or vanish, which the scoreboard sees within two write cycles. A hand-off toggle that fails to clear at reset either shifts the phase of the first pair or produces a phantom load, so the stream no longer matches the queued pairs from the first compare onward. Faults in the selector show up at once, in the same cycle as the loopback or enable change.

// File: rtl/ds_ser_pkg.sv
`timescale 1ns/1ps
package ds_ser_pkg;
    localparam int PAIR_W = 2;
    localparam int PEND_W = PAIR_W - 1;

    typedef struct packed {
        logic [PAIR_W-1:0] d;
        logic [PAIR_W-1:0] s;
    } pair_t;

    typedef struct packed {
        logic d;
        logic s;
    } line_t;

    localparam line_t LINE_IDLE = '{d: 1'b0, s: 1'b0};

    function automatic line_t first_bit(input pair_t p);
        line_t l;
        l.d = p.d[0];
        l.s = p.s[0];
        return l;
    endfunction
endpackage

// File: rtl/ds_pair_capture.sv
`timescale 1ns/1ps
module ds_pair_capture
    import ds_ser_pkg::*;
(
    input  logic  wclk,
    input  logic  rst_n,
    input  pair_t pair_in,
    output pair_t hold_q,
    output logic  wtog_q
);
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            hold_q <= '0;
            wtog_q <= 1'b0;
        end else begin
            hold_q <= pair_in;
            wtog_q <= ~wtog_q;
        end
    end
endmodule

// File: rtl/ds_fast_shift.sv
`timescale 1ns/1ps
module ds_fast_shift
    import ds_ser_pkg::*;
(
    input  logic  tclk,
    input  logic  rst_n,
    input  pair_t hold_q,
    input  logic  wtog_q,
    output line_t ser_q
);
    logic              tog_smp, tog_seen, started;
    logic [PEND_W-1:0] pend_d, pend_s;
    logic              load;

    assign load = tog_smp ^ tog_seen;

    always_ff @(posedge tclk) begin
        if (!rst_n) begin
            tog_smp  <= 1'b0;
            tog_seen <= 1'b0;
            started  <= 1'b0;
            ser_q    <= LINE_IDLE;
            pend_d   <= '0;
            pend_s   <= '0;
        end else begin
            tog_smp  <= wtog_q;
            tog_seen <= tog_smp;
            if (load) begin
                started <= 1'b1;
                ser_q   <= first_bit(hold_q);
                pend_d  <= hold_q.d[PAIR_W-1:1];
                pend_s  <= hold_q.s[PAIR_W-1:1];
            end else begin
                ser_q.d <= pend_d[0];
                ser_q.s <= pend_s[0];
                pend_d  <= pend_d >> 1;
                pend_s  <= pend_s >> 1;
            end
        end
    end

    // R3: a reload is never followed by another on the next edge
    assert_load_gap_R3: assert property (@(posedge tclk) disable iff (!rst_n)
        load |=> !load);

    // R3: once running, a quiet edge is always followed by a reload
    assert_steady_reload_R3: assert property (@(posedge tclk) disable iff (!rst_n)
        (started && !load) |=> load);
endmodule

// File: rtl/ds_out_select.sv
`timescale 1ns/1ps
module ds_out_select
    import ds_ser_pkg::*;
(
    input  logic  oe,
    input  logic  loop_en,
    input  line_t ser,
    input  line_t rx,
    output line_t tx
);
    always_comb begin
        if (!oe)          tx = LINE_IDLE;
        else if (loop_en) tx = rx;
        else              tx = ser;
    end
endmodule

// File: rtl/ds_tx_serializer.sv
`timescale 1ns/1ps
module ds_tx_serializer
    import ds_ser_pkg::*;
(
    input  logic              wclk,
    input  logic              tclk,
    input  logic              rst_n,
    input  logic              tx_oe,
    input  logic              rmt_loop,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic [PAIR_W-1:0] wr_strobe,
    input  logic              rx_data,
    input  logic              rx_strobe,
    output logic              tx_data,
    output logic              tx_strobe
);
    pair_t pair_in, hold_q;
    logic  wtog_q;
    line_t ser_q, rx_line, tx_line;

    assign pair_in.d = wr_data;
    assign pair_in.s = wr_strobe;
    assign rx_line.d = rx_data;
    assign rx_line.s = rx_strobe;

    ds_pair_capture u_cap (
        .wclk(wclk), .rst_n(rst_n), .pair_in(pair_in),
        .hold_q(hold_q), .wtog_q(wtog_q)
    );

    ds_fast_shift u_shift (
        .tclk(tclk), .rst_n(rst_n), .hold_q(hold_q),
        .wtog_q(wtog_q), .ser_q(ser_q)
    );

    ds_out_select u_sel (
        .oe(tx_oe), .loop_en(rmt_loop), .ser(ser_q),
        .rx(rx_line), .tx(tx_line)
    );

    assign tx_data   = tx_line.d;
    assign tx_strobe = tx_line.s;

    // R4: disabled driver parks both lines low
    assert_oe_idle_R4: assert property (@(posedge tclk) disable iff (!rst_n)
        !tx_oe |-> (tx_data == 1'b0 && tx_strobe == 1'b0));

    // R5: enabled loopback mirrors the received lines
    assert_loop_mirror_R5: assert property (@(posedge tclk) disable iff (!rst_n)
        (tx_oe && rmt_loop) |-> (tx_data == rx_data && tx_strobe == rx_strobe));
endmodule

// File: tb/test_ds_tx_serializer.sv
`timescale 1ns/1ps
module test_ds_tx_serializer;
    typedef struct packed {
        logic [1:0] d;
        logic [1:0] s;
    } item_t;

    logic wclk = 1'b0, tclk = 1'b0;
    logic rst_n = 1'b0, tx_oe = 1'b1, rmt_loop = 1'b0;
    logic [1:0] wr_data = '0, wr_strobe = '0;
    logic rx_data = 1'b0, rx_strobe = 1'b0;
    logic tx_data, tx_strobe;

    int checks = 0, errors = 0;
    bit track = 1'b0, done = 1'b0;
    item_t q[$];

    ds_tx_serializer i_ds_tx_serializer (
        .wclk(wclk), .tclk(tclk), .rst_n(rst_n), .tx_oe(tx_oe),
        .rmt_loop(rmt_loop), .wr_data(wr_data), .wr_strobe(wr_strobe),
        .rx_data(rx_data), .rx_strobe(rx_strobe),
        .tx_data(tx_data), .tx_strobe(tx_strobe)
    );

    always #4 tclk = ~tclk;
    initial begin
        #3;
        forever begin
            wclk = ~wclk;
            #8;
        end
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_pair(input logic [1:0] d, input logic [1:0] s);
        item_t it;
        @(negedge wclk);
        wr_data   = d;
        wr_strobe = s;
        it.d = d;
        it.s = s;
        if (track) q.push_back(it);
    endtask

    task automatic check_pair(input item_t it);
        @(posedge tclk);
        @(posedge tclk);
        #1;
        chk("R1 R3 even data", {1'b0, tx_data}, {1'b0, it.d[0]});
        chk("R2 even strobe", {1'b0, tx_strobe}, {1'b0, it.s[0]});
        @(posedge tclk);
        #1;
        chk("R1 R3 odd data", {1'b0, tx_data}, {1'b0, it.d[1]});
        chk("R2 odd strobe", {1'b0, tx_strobe}, {1'b0, it.s[1]});
    endtask

    always @(posedge wclk) begin
        if (q.size() != 0) begin
            item_t cur;
            cur = q.pop_front();
            fork
                check_pair(cur);
            join_none
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R6: outputs stay low in reset even with all-ones inputs
        wr_data = 2'b11;
        wr_strobe = 2'b11;
        for (int i = 0; i < 8; i++) begin
            @(posedge tclk);
            #1;
            chk("R6 reset idle", {tx_data, tx_strobe}, 2'b00);
        end
        @(negedge wclk);
        rst_n = 1'b1;
        repeat (3) send_pair(2'b00, 2'b00);

        // R1 R2 R3: fixed patterns then random stream
        track = 1'b1;
        send_pair(2'b01, 2'b10);
        send_pair(2'b10, 2'b01);
        send_pair(2'b11, 2'b00);
        send_pair(2'b00, 2'b11);
        for (int i = 0; i < 40; i++)
            send_pair(2'($urandom), 2'($urandom));
        track = 1'b0;
        repeat (4) send_pair(2'b00, 2'b00);

        // R5: loopback mirrors rx in the same cycle
        rmt_loop = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge tclk);
            rx_data   = 1'($urandom);
            rx_strobe = 1'($urandom);
            #1;
            chk("R5 loopback", {tx_data, tx_strobe}, {rx_data, rx_strobe});
        end

        // R4: oe low wins over loopback
        rx_data = 1'b1;
        rx_strobe = 1'b1;
        tx_oe = 1'b0;
        #1;
        chk("R4 oe low with loopback", {tx_data, tx_strobe}, 2'b00);

        // R7: loopback off resumes the stream
        tx_oe = 1'b1;
        rmt_loop = 1'b0;
        send_pair(2'b00, 2'b00);
        track = 1'b1;
        for (int i = 0; i < 8; i++)
            send_pair(2'($urandom), 2'($urandom));
        send_pair(2'b11, 2'b11);
        track = 1'b0;
        repeat (4) send_pair(2'b11, 2'b11);

        // R4: oe low during an all-ones stream
        tx_oe = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge tclk);
            #1;
            chk("R4 oe low stream", {tx_data, tx_strobe}, 2'b00);
        end

        // R4: oe low during reset
        @(negedge wclk);
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge tclk);
            #1;
            chk("R4 oe low in reset", {tx_data, tx_strobe}, 2'b00);
        end

        // R6: reset with output enabled and ones on the inputs
        tx_oe = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge tclk);
            #1;
            chk("R6 reset idle enabled", {tx_data, tx_strobe}, 2'b00);
        end
        @(negedge wclk);
        rst_n = 1'b1;
        repeat (3) send_pair(2'b00, 2'b00);
        track = 1'b1;
        for (int i = 0; i < 6; i++)
            send_pair(2'($urandom), 2'($urandom));
        track = 1'b0;
        repeat (4) send_pair(2'b00, 2'b00);
        finish_run();
    end
endmodule